// File: doc/BRIEF.md
# Over-Temperature Alarm Latch

This block sits beside a converter and watches every result it produces. When a result from the temperature-sensor channel is larger than a programmable 8-bit limit, the block latches an alarm and pulls the alarm line low. The alarm is sticky. It does not clear when the temperature falls again. It clears only when the serial interface reports that a read transaction has finished.

The limit lives in an 8-bit register with a simple write-enable and data port, and it resets to 80. The comparison uses the most significant eight bits of the converter result. The alarm line is modelled as an open-drain enable: when the enable is high, the pad drives low, and when it is low, the pad is released.

Top module: `otAlarmLatch`

## Requirements
- R1: After reset the alarm enable is 0 and the limit holds 80. A channel-0 sample of 80 does not set the alarm, and a sample of 81 does.
- R2: Only samples tagged with channel number 0 are compared. A sample on any other channel never sets the alarm.
- R3: The alarm sets only when the sample is strictly greater than the limit. A sample equal to the limit does not set it.
- R4: The compared value is bits [9:2] of the 10-bit result. Bits [1:0] have no effect on the decision.
- R5: Once set, the alarm stays asserted through later samples that are below the limit, and while no strobe is present, until a read-done pulse arrives.
- R6: A read-done pulse with no qualifying sample in the same cycle clears the alarm enable in the following cycle.
- R7: If a qualifying sample and a read-done pulse arrive in the same cycle, the alarm is asserted (or stays asserted) in the following cycle.
- R8: A limit write takes effect for samples in later cycles. A sample presented in the same cycle as the write is compared against the old limit.
- R9: The alarm enable rises in the cycle after the qualifying strobe. Without the result-valid strobe, the data and channel inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | One-cycle strobe: a converter result is present |
| resChan | input | 3 | Channel number of the result |
| resData | input | 10 | Converter result |
| thrWrEn | input | 1 | Limit register write enable |
| thrWrData | input | 8 | New limit value |
| readDone | input | 1 | One-cycle pulse: a serial read has completed |
| alarmOe | output | 1 | Open-drain enable: 1 pulls the alarm line low |

## Verification
The properties assume that resValid and readDone are single-cycle pulses, and that reset is held long enough to load the limit register. The properties also read the limit register directly, so they assume that only the write port changes it. The bench drives every input on the falling clock edge and issues each strobe for exactly one cycle. It also places limit writes, read-done pulses and samples in the same cycle on purpose, so that the ordering rules in R7 and R8 are exercised within those assumptions.

// File: rtl/otAlarmPkg.sv
package otAlarmPkg;
  typedef struct packed {
    logic loadThr;
    logic setAlarm;
    logic clrAlarm;
  } otStrobes_t;
endpackage

// File: rtl/otAlarmControl.sv
module otAlarmControl #(
  parameter int CHAN_W    = 3,
  parameter int TEMP_CHAN = 0
) (
  input  logic                   resValid,
  input  logic [CHAN_W-1:0]      resChan,
  input  logic                   overThr,
  input  logic                   readDone,
  input  logic                   thrWrEn,
  output otAlarmPkg::otStrobes_t strobes
);
  localparam logic [CHAN_W-1:0] TempChanSel = CHAN_W'(TEMP_CHAN);

  logic isTempSample;

  always_comb begin
    isTempSample     = resValid && (resChan == TempChanSel);
    strobes.setAlarm = isTempSample && overThr;
    // set has priority over a same-cycle clear
    strobes.clrAlarm = readDone && !strobes.setAlarm;
    strobes.loadThr  = thrWrEn;
  end
endmodule

// File: rtl/otAlarmDatapath.sv
module otAlarmDatapath #(
  parameter int          RES_W     = 10,
  parameter int          THR_W     = 8,
  parameter logic [7:0]  THR_RESET = 8'd80
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [RES_W-1:0]       resData,
  input  logic [THR_W-1:0]       thrWrData,
  input  otAlarmPkg::otStrobes_t strobes,
  output logic                   overThr,
  output logic                   alarmQ,
  output logic [THR_W-1:0]       thrQ
);
  logic [THR_W-1:0] resTop;

  generate
    if (RES_W >= THR_W) begin : gSlice
      assign resTop = resData[RES_W-1 -: THR_W];
    end else begin : gPad
      assign resTop = {resData, {(THR_W-RES_W){1'b0}}};
    end
  endgenerate

  assign overThr = resTop > thrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrQ   <= THR_W'(THR_RESET);
      alarmQ <= 1'b0;
    end else begin
      if (strobes.loadThr)       thrQ   <= thrWrData;
      if (strobes.setAlarm)      alarmQ <= 1'b1;
      else if (strobes.clrAlarm) alarmQ <= 1'b0;
    end
  end
endmodule

// File: rtl/otAlarmLatch.sv
module otAlarmLatch #(
  parameter int          RES_W     = 10,
  parameter int          THR_W     = 8,
  parameter int          CHAN_W    = 3,
  parameter int          TEMP_CHAN = 0,
  parameter logic [7:0]  THR_RESET = 8'd80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [RES_W-1:0]  resData,
  input  logic              thrWrEn,
  input  logic [THR_W-1:0]  thrWrData,
  input  logic              readDone,
  output logic              alarmOe
);
  otAlarmPkg::otStrobes_t strobes;
  logic                   overThr;
  logic                   alarmQ;
  logic [THR_W-1:0]       thrQ;

  otAlarmControl #(.CHAN_W(CHAN_W), .TEMP_CHAN(TEMP_CHAN)) uCtrl (
    .resValid(resValid), .resChan(resChan), .overThr(overThr),
    .readDone(readDone), .thrWrEn(thrWrEn), .strobes(strobes)
  );

  otAlarmDatapath #(.RES_W(RES_W), .THR_W(THR_W), .THR_RESET(THR_RESET)) uDp (
    .clk(clk), .rstN(rstN), .resData(resData), .thrWrData(thrWrData),
    .strobes(strobes), .overThr(overThr), .alarmQ(alarmQ), .thrQ(thrQ)
  );

  assign alarmOe = alarmQ;
endmodule

// File: rtl/otAlarmChecker.sv
module otAlarmChecker #(
  parameter int RES_W     = 10,
  parameter int THR_W     = 8,
  parameter int CHAN_W    = 3,
  parameter int TEMP_CHAN = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              resValid,
  input logic [CHAN_W-1:0] resChan,
  input logic [RES_W-1:0]  resData,
  input logic              thrWrEn,
  input logic [THR_W-1:0]  thrWrData,
  input logic              readDone,
  input logic              alarmOe,
  input logic [THR_W-1:0]  thrQ
);
  logic hot;
  assign hot = resValid && (resChan == CHAN_W'(TEMP_CHAN)) &&
               (resData[RES_W-1 -: THR_W] > thrQ);

  // R2 / R3 / R9: nothing sets the alarm without a hot channel-0 sample
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    !alarmOe && !hot |=> !alarmOe);
  // R5
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    alarmOe && !readDone |=> alarmOe);
  // R6
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    readDone && !hot |=> !alarmOe);
  // R7
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    hot |=> alarmOe);
  // R8
  a_r8_thr_load: assert property (@(posedge clk) disable iff (!rstN)
    thrWrEn |=> thrQ == $past(thrWrData));
  // R8
  a_r8_thr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !thrWrEn |=> $stable(thrQ));
endmodule

bind otAlarmLatch otAlarmChecker #(
  .RES_W(RES_W), .THR_W(THR_W), .CHAN_W(CHAN_W), .TEMP_CHAN(TEMP_CHAN)
) uChk (
  .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
  .resData(resData), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
  .readDone(readDone), .alarmOe(alarmOe), .thrQ(thrQ)
);

// File: tb/sim_otAlarmLatch.sv
module sim_otAlarmLatch;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       resValid = 1'b0;
  logic [2:0] resChan = 3'd0;
  logic [9:0] resData = 10'd0;
  logic       thrWrEn = 1'b0;
  logic [7:0] thrWrData = 8'd0;
  logic       readDone = 1'b0;
  logic       alarmOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";

  int modelThr = 80;
  bit modelAlarm = 0;

  always #10 clk = ~clk;

  otAlarmLatch u0 (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .resData(resData), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .readDone(readDone), .alarmOe(alarmOe)
  );

  // behavioural reference model
  always @(posedge clk) begin
    bit hot;
    if (!rstN) begin
      modelThr = 80;
      modelAlarm = 0;
    end else begin
      hot = resValid && (resChan == 0) && (int'(resData) / 4 > modelThr);
      if (hot) modelAlarm = 1;
      else if (readDone) modelAlarm = 0;
      if (thrWrEn) modelThr = thrWrData;
    end
  end

  task automatic compare();
    checks++;
    if (alarmOe !== modelAlarm) begin
      errors++;
      $display("FAIL %s: alarmOe actual %0b expected %0b at %0t", curReq, alarmOe, modelAlarm, $time);
    end
  endtask

  // one cycle: check the outcome of the previous cycle, then drive new inputs
  task automatic step(input bit v, input int ch, input int top, input int lo,
                      input bit rd, input bit we, input int wd);
    @(negedge clk);
    compare();
    resValid  = v;
    resChan   = 3'(ch);
    resData   = {8'(top), 2'(lo)};
    readDone  = rd;
    thrWrEn   = we;
    thrWrData = 8'(wd);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic expectNow(input bit exp);
    @(negedge clk);
    checks++;
    if (alarmOe !== exp) begin
      errors++;
      $display("FAIL %s: alarmOe actual %0b expected %0b at %0t", curReq, alarmOe, exp, $time);
    end
    resValid = 0; readDone = 0; thrWrEn = 0;
  endtask

  task automatic clearAlarm(); step(0, 0, 0, 0, 1, 0, 0); idle(); endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1";
    expectNow(0);                       // R1 reset state
    step(1, 0, 80, 3, 0, 0, 0);         // R1 default limit: equal, no set
    expectNow(0);
    step(1, 0, 81, 0, 0, 0, 0);         // R1: 81 sets
    expectNow(1);
    clearAlarm();

    curReq = "R2";
    for (int c = 1; c < 8; c++) step(1, c, 255, 3, 0, 0, 0);
    expectNow(0);

    curReq = "R3";
    step(0, 0, 0, 0, 0, 1, 150);
    step(1, 0, 150, 0, 0, 0, 0);
    expectNow(0);
    step(1, 0, 151, 0, 0, 0, 0);
    expectNow(1);
    clearAlarm();

    curReq = "R4";
    step(1, 0, 150, 3, 0, 0, 0);        // low bits set, top equal: no alarm
    expectNow(0);
    step(1, 0, 149, 3, 0, 0, 0);
    expectNow(0);

    curReq = "R5";
    step(1, 0, 200, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 10, 0, 0, 0, 0);
    idle(); idle();
    expectNow(1);

    curReq = "R6";
    step(0, 0, 0, 0, 1, 0, 0);
    expectNow(0);
    step(1, 2, 255, 0, 1, 0, 0);        // other channel plus read-done
    expectNow(0);

    curReq = "R7";
    step(1, 0, 220, 0, 1, 0, 0);        // set and clear together from clear
    expectNow(1);
    step(1, 0, 220, 0, 1, 0, 0);        // set and clear together while set
    expectNow(1);
    clearAlarm();

    curReq = "R8";
    step(1, 0, 100, 0, 0, 1, 90);       // compared against old limit 150
    expectNow(0);
    step(1, 0, 100, 0, 0, 0, 0);        // new limit 90 applies
    expectNow(1);
    clearAlarm();
    step(1, 0, 100, 0, 0, 1, 120);      // old limit 90: sets
    expectNow(1);
    clearAlarm();
    step(1, 0, 100, 0, 0, 0, 0);        // limit 120: no set
    expectNow(0);
    step(0, 0, 0, 0, 0, 1, 0);          // limit 0
    step(1, 0, 0, 3, 0, 0, 0);          // 0 not > 0
    expectNow(0);
    step(1, 0, 1, 0, 0, 0, 0);
    expectNow(1);
    clearAlarm();

    curReq = "R9";
    step(0, 0, 255, 3, 0, 0, 0);        // data without strobe
    expectNow(0);
    step(1, 0, 255, 3, 0, 0, 0);
    @(negedge clk);                     // the edge that registers the sample
    checks++;
    if (alarmOe !== 1'b1) begin
      errors++;
      $display("FAIL R9: alarmOe actual %0b expected 1 after strobe", alarmOe);
    end
    resValid = 0;
    idle();

    // mixed traffic compared every cycle against the model
    curReq = "R5";
    for (int i = 0; i < 200; i++)
      step((i % 3) != 0, i % 5 == 0 ? 0 : i % 4, (i * 37) % 256, i % 4,
           (i % 11) == 0, (i % 17) == 0, (i * 53) % 256);
    idle(); idle();

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule